// File: doc/BRIEF.md
# Multi-Rail Reset and Watchdog Supervisor

This block is the synchronous decision logic behind a three-rail supply supervisor. Comparators elsewhere on the chip turn each monitored rail into a digital "rail good" flag. The block combines these flags with an active-low manual reset request and a periodic watchdog kick from software. From them it produces two active-low outputs: a system reset and a watchdog alarm. Each output has its own timing rules.

The reset output drops in the same cycle that any rail flag goes low. It also drops once a filtered manual-reset request is seen. After every cause has cleared, reset is held for a programmable timeout: one of four periods, each double the one before. Manual reset is first passed through a synchronizer and then a filter, so short glitches cannot reach the output.

The watchdog alarm is separate from reset and cannot be turned off. Once it has fired on a missed kick it latches. It is also forced low while any rail is bad and is released as soon as the rails recover, without waiting for the reset hold. All times are counted in clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `supply_supervisor`

## Requirements
- R1: While any bit of `rail_ok_i` is 0, `rst_n_o` is 0 in the same cycle, with no clock edge needed.
- R2: A `mr_n_i` low level lasting at least one microsecond drives `rst_n_o` to 0. Reset is then released a hold period after `mr_n_i` returns high.
- R3: `rst_n_o` returns to 1 exactly `(RST_BASE_US*CYC_PER_US) << tsel_i` cycles after the last cause clears, within a few cycles of margin. `tsel_i` values 0, 1, 2 and 3 select 1x, 2x, 4x and 8x the base period (50, 100, 200 and 400 ms by default).
- R4: A cause that returns during the hold restarts the hold from its full length.
- R5: A `mr_n_i` low pulse shorter than half a microsecond (fewer than `(CYC_PER_US+1)/2` cycles) is ignored: `rst_n_o` stays 1.
- R6: If `kick_i` does not toggle for `WDOG_US*CYC_PER_US` cycles, `wdo_n_o` goes to 0 and `rst_n_o` is left unchanged.
- R7: After a watchdog expiry, `wdo_n_o` stays 0 until a `kick_i` transition (either edge). It then returns to 1 within four cycles, with no reset hold.
- R8: The watchdog count restarts on a kick transition, while reset is asserted, and while manual reset is active.
- R9: While any rail is bad, `wdo_n_o` is 0. It returns to 1 in the cycle the rails recover, even though `rst_n_o` is still being held.
- R10: Manual reset never drives `wdo_n_o` low.
- R11: While `rst_n` is low, `rst_n_o` is 0 and `wdo_n_o` is 1 (all rails good). After `rst_n` releases, `rst_n_o` stays 0 for the selected hold period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rail_ok_i | input | N_RAIL | Per-rail supply-good flags, 1 = good |
| mr_n_i | input | 1 | Asynchronous manual reset request, active low |
| kick_i | input | 1 | Asynchronous watchdog kick; any transition counts |
| tsel_i | input | 2 | Reset hold select, period = base << tsel_i |
| rst_n_o | output | 1 | System reset, active low |
| wdo_n_o | output | 1 | Watchdog alarm, active low |

## Verification
The bench drops a different rail, or all rails, under each hold select. It checks that the watchdog alarm releases at once while reset remains held; a design that tied the alarm to the reset hold would keep it low. A cause returning mid-hold must stretch reset past its original end, which a non-restarting counter would miss.

A one-cycle manual-reset glitch must leave reset high, while a long pulse must assert reset without touching the alarm. An unfiltered or alarm-coupled manual reset would fail one of these two checks. The watchdog is shown to latch until a kick, to be kept alive by kicks spaced under the period, and to be restarted by manual reset; a counter that manual reset did not clear would expire early.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {HOLD_X1 = 2'd0, HOLD_X2 = 2'd1, HOLD_X4 = 2'd2, HOLD_X8 = 2'd3} hold_sel_e;

  function automatic int filt_cycles(input int cyc_per_us);
    int f;
    f = (cyc_per_us + 1) / 2;
    return (f < 1) ? 1 : f;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_act_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (mr_n_s)
      cnt_d = '0;
    else if (cnt_q != FULL)
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mr_act_o = (cnt_q == FULL);
endmodule

// File: rtl/supv_rst_timer.sv
module supv_rst_timer #(
  parameter int BASE_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cause_i,
  input  logic [1:0] sel_i,
  output logic       hold_o
);
  localparam int MAXC = BASE_CYC * 8;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          hold_q, hold_d;

  assign lim = CW'(BASE_CYC) << sel_i;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (cause_i) begin
      cnt_d  = '0;
      hold_d = 1'b1;
    end else if (hold_q) begin
      if (cnt_q >= lim - CW'(1)) begin
        cnt_d  = '0;
        hold_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int LIM_CYC = 16000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIM_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LIM_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (kick_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (clr_i) begin
      cnt_d = '0;
    end else if (!exp_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int CYC_PER_US  = 10,
  parameter int RST_BASE_US = 50000,
  parameter int WDOG_US     = 1600000,
  parameter int N_RAIL      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RAIL-1:0] rail_ok_i,
  input  logic              mr_n_i,
  input  logic              kick_i,
  input  logic [1:0]        tsel_i,
  output logic              rst_n_o,
  output logic              wdo_n_o
);
  import supv_pkg::*;

  localparam int FILT_CYC = filt_cycles(CYC_PER_US);
  localparam int BASE_CYC = RST_BASE_US * CYC_PER_US;
  localparam int WDOG_CYC = WDOG_US * CYC_PER_US;

  logic [1:0] raw_in, syn_in;
  logic       mr_n_s, kick_s;
  logic       kick_prev_q, kick_prev_d;
  logic       kick_edge;
  logic       mr_act;
  logic       rail_bad;
  logic       cause;
  logic       hold;
  logic       expired;

  assign raw_in = {mr_n_i, kick_i};

  supv_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign mr_n_s = syn_in[1];
  assign kick_s = syn_in[0];

  assign kick_prev_d = kick_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_prev_q <= 1'b1;
    else        kick_prev_q <= kick_prev_d;
  end

  assign kick_edge = kick_s ^ kick_prev_q;

  supv_mr_filter #(.FILT_CYC(FILT_CYC)) u_mr (
    .clk(clk), .rst_n(rst_n), .mr_n_s(mr_n_s), .mr_act_o(mr_act)
  );

  assign rail_bad = ~&rail_ok_i;
  assign cause    = rail_bad | mr_act;

  supv_rst_timer #(.BASE_CYC(BASE_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .cause_i(cause), .sel_i(tsel_i), .hold_o(hold)
  );

  supv_wdog #(.LIM_CYC(WDOG_CYC)) u_wd (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_edge),
    .clr_i(cause | hold), .expired_o(expired)
  );

  assign rst_n_o = ~(cause | hold);
  assign wdo_n_o = ~(rail_bad | expired);
endmodule

// File: rtl/supv_chk.sv
module supv_chk #(
  parameter int N_RAIL = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_RAIL-1:0] rail_ok_i,
  input logic              mr_act,
  input logic              kick_edge,
  input logic              rst_n_o,
  input logic              wdo_n_o
);
  // R1
  rail_low_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&rail_ok_i) |-> !rst_n_o);

  // R9
  rail_low_wdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&rail_ok_i) |-> !wdo_n_o);

  // R3
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> ((&rail_ok_i) && !mr_act));

  // R4
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&rail_ok_i) || mr_act) |=> !rst_n_o);

  // R7
  wdo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n_o && (&rail_ok_i) && !kick_edge) |=> !wdo_n_o);
endmodule

bind supply_supervisor supv_chk #(.N_RAIL(N_RAIL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rail_ok_i(rail_ok_i), .mr_act(mr_act),
  .kick_edge(kick_edge), .rst_n_o(rst_n_o), .wdo_n_o(wdo_n_o)
);

// File: tb/supply_supervisor_bench.sv
module supply_supervisor_bench;
  localparam int CP   = 4;
  localparam int RB   = 10;
  localparam int WD   = 200;
  localparam int BASE = RB * CP;
  localparam int WDC  = WD * CP;

  // {failing-rail pattern, hold select}
  localparam logic [4:0] VEC [4] = '{
    {3'b110, 2'd0}, {3'b101, 2'd1}, {3'b011, 2'd2}, {3'b000, 2'd3}
  };

  logic       clk, rst_n, mr_n, kick, rst_n_o, wdo_n_o;
  logic [2:0] rail;
  logic [1:0] tsel;
  int errors, checks;
  bit done;

  supply_supervisor #(.CYC_PER_US(CP), .RST_BASE_US(RB), .WDOG_US(WD), .N_RAIL(3))
  u_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .rail_ok_i(rail), .mr_n_i(mr_n), .kick_i(kick),
    .tsel_i(tsel), .rst_n_o(rst_n_o), .wdo_n_o(wdo_n_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    errors = 0; checks = 0; done = 0;
    rst_n = 0; rail = 3'b111; mr_n = 1; kick = 0; tsel = 2'd0;
    step(3);
    chk(rst_n_o, 1'b0, "R11 rst in reset");
    chk(wdo_n_o, 1'b1, "R11 wdo in reset");
    rst_n = 1;
    step(BASE - 3);
    chk(rst_n_o, 1'b0, "R11 hold after power-on");
    step(5);
    chk(rst_n_o, 1'b1, "R3 release after power-on");

    for (int i = 0; i < 4; i++) begin
      int lim;
      tsel = VEC[i][1:0];
      lim  = BASE << VEC[i][1:0];
      rail = VEC[i][4:2];
      #1;
      chk(rst_n_o, 1'b0, "R1 rail drop asserts reset");
      chk(wdo_n_o, 1'b0, "R9 rail drop asserts wdo");
      step(2);
      rail = 3'b111;
      #1;
      chk(wdo_n_o, 1'b1, "R9 wdo released at once");
      chk(rst_n_o, 1'b0, "R3 reset still held");
      step(lim - 3);
      chk(rst_n_o, 1'b0, "R3 held before period end");
      step(5);
      chk(rst_n_o, 1'b1, "R3 released after period");
    end
    tsel = 2'd0;

    step(WDC - 20);
    chk(wdo_n_o, 1'b1, "R6 wdo before expiry");
    step(40);
    chk(wdo_n_o, 1'b0, "R6 wdo expired");
    chk(rst_n_o, 1'b1, "R6 reset untouched by expiry");
    step(100);
    chk(wdo_n_o, 1'b0, "R7 wdo latched");
    kick = ~kick;
    step(4);
    chk(wdo_n_o, 1'b1, "R7 wdo cleared by kick");

    for (int k = 0; k < 3; k++) begin
      step(600);
      kick = ~kick;
    end
    step(600);
    chk(wdo_n_o, 1'b1, "R8 kicks keep wdo high");
    kick = ~kick;
    step(10);

    step(500);
    mr_n = 0;
    step(8);
    chk(rst_n_o, 1'b0, "R2 manual reset asserts");
    chk(wdo_n_o, 1'b1, "R10 manual reset leaves wdo");
    mr_n = 1;
    step(BASE - 8);
    chk(rst_n_o, 1'b0, "R2 hold after manual release");
    step(16);
    chk(rst_n_o, 1'b1, "R2 release after manual hold");
    step(600);
    chk(wdo_n_o, 1'b1, "R8 manual reset cleared count");
    step(300);
    chk(wdo_n_o, 1'b0, "R8 expiry after restart");
    kick = ~kick;
    step(4);

    mr_n = 0;
    step(1);
    mr_n = 1;
    step(6);
    chk(rst_n_o, 1'b1, "R5 glitch rejected");

    rail = 3'b110;
    step(2);
    rail = 3'b111;
    step(20);
    chk(rst_n_o, 1'b0, "R4 first hold");
    rail = 3'b110;
    step(1);
    rail = 3'b111;
    step(30);
    chk(rst_n_o, 1'b0, "R4 hold restarted");
    step(15);
    chk(rst_n_o, 1'b1, "R4 release after restart");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule